// File: doc/BRIEF.md
# DFI Phase Command Injector

This block lets software place hand-built commands on a single phase of a DRAM PHY command interface. This is useful for bring-up, mode-register programming and PHY training. Software uses a 32-bit word-addressed register bus to load the following values: a command word, a row/column address, a bank address and a write-data word. A write to the issue register then plays the command onto the phase for exactly one clock cycle.

Address, bank and write data are driven statically from their registers. The command strobes and the data-path enables are gated by a one-cycle issue pulse. Outside that pulse the phase sits in a no-operation state: every active-low strobe is high and both enables are low. A control register bit drives the clock-enable output.

Top module: `dfi_phase_injector`

## Requirements
- R1: After reset, csN, weN, casN, rasN and actN are high, wrdataEn, rddataEn, wrdataMask, cke and busAck are low, and the address, bank and wrdata outputs are zero.
- R2: An access is accepted on a clock edge where busCyc and busStb are high and busAck is low. busAck is then high for exactly one cycle after that edge.
- R3: Register word indices are as follows: 0 is control, 1 is issue, 2 is address, 3 is bank, 4 is command and 5 is write data. Writes to any other index change no output, and reads of any other index return zero.
- R4: A write updates only the bytes whose busSel bit is set. busSel bit n covers data bits 8n+7 to 8n. Bytes whose busSel bit is clear are not updated, including the control register.
- R5: The address output shows the address register truncated to ADDR_W (14) bits. The bank output shows the bank register truncated to BANK_W (3) bits. Each changes only on a write to its register.
- R6: The wrdata output shows the write-data register, which is DATA_W (16) bits wide.
- R7: The cke output equals bit 1 of the control register. Writing 1 to that bit drives cke high, and writing 0 drives it low.
- R8: The command register bits map to strobes as follows: bit 0 to csN, bit 1 to weN, bit 2 to casN and bit 3 to rasN. Each selected strobe is low only during the issue cycle. Every strobe is high in any cycle not preceded by an accepted issue write.
- R9: Bit 4 of the command register enables a wrdataEn pulse, and bit 5 enables a rddataEn pulse. Each accepted issue write, whatever its value, produces exactly one pulse. The pulse lasts one cycle and is high in the cycle after acceptance.
- R10: A read returns the stored, truncated register contents with the same one-cycle acknowledge. A read of the issue register returns zero.
- R11: actN is always high and wrdataMask is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busCyc | input | 1 | Bus cycle valid |
| busStb | input | 1 | Bus strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAdr | input | ADR_W (8) | Word index |
| busDatW | input | 32 | Write data |
| busSel | input | 4 | Byte lane enables |
| busDatR | output | 32 | Read data, valid with busAck |
| busAck | output | 1 | One-cycle acknowledge |
| cke | output | 1 | Clock enable |
| csN | output | 1 | Chip select, active low |
| weN | output | 1 | Write enable strobe, active low |
| casN | output | 1 | Column strobe, active low |
| rasN | output | 1 | Row strobe, active low |
| actN | output | 1 | Activate strobe, active low, held high |
| address | output | ADDR_W (14) | Row/column address |
| bank | output | BANK_W (3) | Bank address |
| wrdata | output | DATA_W (16) | Write data |
| wrdataMask | output | DATA_W/8 (2) | Write data mask, held low |
| wrdataEn | output | 1 | Write data enable pulse |
| rddataEn | output | 1 | Read data enable pulse |

## Verification
The hardest situation to observe is the issue pulse, which lives for only one cycle. That cycle coincides with the bus acknowledge, so it cannot be seen by reading registers back. The bench samples every strobe in that exact cycle and again one cycle later. It also counts enable pulses on a free-running monitor, so two issue writes must show as two separate pulses, including a write whose value is zero. Byte-lane masking is reached by partial writes over previously filled registers, and each result is read back through the bus.

// File: rtl/dfi_inj_pkg.sv
package dfi_inj_pkg;
  localparam int BUS_W   = 32;
  localparam int LANES   = BUS_W / 8;
  localparam int CMD_W   = 6;
  localparam int CMD_CS  = 0;
  localparam int CMD_WE  = 1;
  localparam int CMD_CAS = 2;
  localparam int CMD_RAS = 3;
  localparam int CMD_WEN = 4;
  localparam int CMD_REN = 5;
  localparam int CTRL_CKE = 1;

  typedef enum logic [2:0] {
    RS_CTRL  = 3'd0,
    RS_ISSUE = 3'd1,
    RS_ADDR  = 3'd2,
    RS_BANK  = 3'd3,
    RS_CMD   = 3'd4,
    RS_WDATA = 3'd5,
    RS_NONE  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    regSel_e           sel;
    logic [BUS_W-1:0]  laneMask;
  } busStrobe_t;
endpackage

// File: rtl/dfi_inj_ctrl.sv
module dfi_inj_ctrl
  import dfi_inj_pkg::*;
#(
  parameter int ADR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busCyc,
  input  logic             busStb,
  input  logic             busWe,
  input  logic [ADR_W-1:0] busAdr,
  input  logic [LANES-1:0] busSel,
  output logic             busAck,
  output busStrobe_t       strb
);
  localparam int LAST_IDX = 5;

  logic    req;
  regSel_e selDec;

  assign req = busCyc & busStb & ~busAck;

  always_ff @(posedge clk) begin
    if (!rstN) busAck <= 1'b0;
    else       busAck <= req;
  end

  always_comb begin
    if (busAdr <= ADR_W'(LAST_IDX)) selDec = regSel_e'(busAdr[2:0]);
    else                            selDec = RS_NONE;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign strb.laneMask[8*g +: 8] = {8{busSel[g]}};
  end

  assign strb.wrEn = req & busWe;
  assign strb.rdEn = req & ~busWe;
  assign strb.sel  = selDec;
endmodule

// File: rtl/dfi_inj_datapath.sv
module dfi_inj_datapath
  import dfi_inj_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3,
  parameter int DATA_W = 16,
  localparam int MASK_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strb,
  input  logic [BUS_W-1:0]  busDatW,
  output logic [BUS_W-1:0]  busDatR,
  output logic              cke,
  output logic              csN,
  output logic              weN,
  output logic              casN,
  output logic              rasN,
  output logic              actN,
  output logic [ADDR_W-1:0] address,
  output logic [BANK_W-1:0] bank,
  output logic [DATA_W-1:0] wrdata,
  output logic [MASK_W-1:0] wrdataMask,
  output logic              wrdataEn,
  output logic              rddataEn
);
  logic              ckeQ;
  logic              issueQ;
  logic [ADDR_W-1:0] addrQ;
  logic [BANK_W-1:0] bankQ;
  logic [CMD_W-1:0]  cmdQ;
  logic [DATA_W-1:0] wdataQ;
  logic [BUS_W-1:0]  rdMux;
  logic [BUS_W-1:0]  ctrlWord;

  function automatic logic [BUS_W-1:0] laneMerge(input logic [BUS_W-1:0] oldV,
                                                 input logic [BUS_W-1:0] newV,
                                                 input logic [BUS_W-1:0] mask);
    return (oldV & ~mask) | (newV & mask);
  endfunction

  assign ctrlWord = BUS_W'(ckeQ) << CTRL_CKE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckeQ   <= 1'b0;
      issueQ <= 1'b0;
      addrQ  <= '0;
      bankQ  <= '0;
      cmdQ   <= '0;
      wdataQ <= '0;
    end else begin
      issueQ <= strb.wrEn && (strb.sel == RS_ISSUE);
      if (strb.wrEn) begin
        unique case (strb.sel)
          RS_CTRL:  ckeQ   <= laneMerge(ctrlWord, busDatW, strb.laneMask)[CTRL_CKE];
          RS_ADDR:  addrQ  <= ADDR_W'(laneMerge(BUS_W'(addrQ), busDatW, strb.laneMask));
          RS_BANK:  bankQ  <= BANK_W'(laneMerge(BUS_W'(bankQ), busDatW, strb.laneMask));
          RS_CMD:   cmdQ   <= CMD_W'(laneMerge(BUS_W'(cmdQ), busDatW, strb.laneMask));
          RS_WDATA: wdataQ <= DATA_W'(laneMerge(BUS_W'(wdataQ), busDatW, strb.laneMask));
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (strb.sel)
      RS_CTRL:  rdMux = ctrlWord;
      RS_ADDR:  rdMux = BUS_W'(addrQ);
      RS_BANK:  rdMux = BUS_W'(bankQ);
      RS_CMD:   rdMux = BUS_W'(cmdQ);
      RS_WDATA: rdMux = BUS_W'(wdataQ);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          busDatR <= '0;
    else if (strb.rdEn) busDatR <= rdMux;
  end

  assign cke        = ckeQ;
  assign csN        = ~(issueQ & cmdQ[CMD_CS]);
  assign weN        = ~(issueQ & cmdQ[CMD_WE]);
  assign casN       = ~(issueQ & cmdQ[CMD_CAS]);
  assign rasN       = ~(issueQ & cmdQ[CMD_RAS]);
  assign actN       = 1'b1;
  assign wrdataEn   = issueQ & cmdQ[CMD_WEN];
  assign rddataEn   = issueQ & cmdQ[CMD_REN];
  assign address    = addrQ;
  assign bank       = bankQ;
  assign wrdata     = wdataQ;
  assign wrdataMask = '0;
endmodule

// File: rtl/dfi_phase_injector.sv
module dfi_phase_injector
  import dfi_inj_pkg::*;
#(
  parameter int ADR_W  = 8,
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busCyc,
  input  logic                busStb,
  input  logic                busWe,
  input  logic [ADR_W-1:0]    busAdr,
  input  logic [31:0]         busDatW,
  input  logic [3:0]          busSel,
  output logic [31:0]         busDatR,
  output logic                busAck,
  output logic                cke,
  output logic                csN,
  output logic                weN,
  output logic                casN,
  output logic                rasN,
  output logic                actN,
  output logic [ADDR_W-1:0]   address,
  output logic [BANK_W-1:0]   bank,
  output logic [DATA_W-1:0]   wrdata,
  output logic [DATA_W/8-1:0] wrdataMask,
  output logic                wrdataEn,
  output logic                rddataEn
);
  busStrobe_t strb;

  dfi_inj_ctrl #(.ADR_W(ADR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busCyc(busCyc), .busStb(busStb), .busWe(busWe),
    .busAdr(busAdr), .busSel(busSel), .busAck(busAck), .strb(strb)
  );

  dfi_inj_datapath #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .busDatW(busDatW), .busDatR(busDatR),
    .cke(cke), .csN(csN), .weN(weN), .casN(casN), .rasN(rasN), .actN(actN),
    .address(address), .bank(bank), .wrdata(wrdata), .wrdataMask(wrdataMask),
    .wrdataEn(wrdataEn), .rddataEn(rddataEn)
  );
endmodule

// File: rtl/dfi_inj_chk.sv
module dfi_inj_chk #(
  parameter int ADR_W  = 8,
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3,
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                busCyc,
  input logic                busStb,
  input logic                busWe,
  input logic [ADR_W-1:0]    busAdr,
  input logic [31:0]         busDatW,
  input logic [3:0]          busSel,
  input logic [31:0]         busDatR,
  input logic                busAck,
  input logic                cke,
  input logic                csN,
  input logic                weN,
  input logic                casN,
  input logic                rasN,
  input logic                actN,
  input logic [ADDR_W-1:0]   address,
  input logic [BANK_W-1:0]   bank,
  input logic [DATA_W-1:0]   wrdata,
  input logic [DATA_W/8-1:0] wrdataMask,
  input logic                wrdataEn,
  input logic                rddataEn
);
  logic accepted;
  assign accepted = busCyc && busStb && !busAck;

  // R2
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> busAck);

  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);

  // R7
  cke_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && busWe && busAdr == ADR_W'(0) && busSel[0]) |=> (cke == $past(busDatW[1])));

  // R8
  idle_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(accepted && busWe && busAdr == ADR_W'(1))
      |=> (csN && weN && casN && rasN && !wrdataEn && !rddataEn));

  // R9
  wen_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrdataEn |=> !wrdataEn);

  // R9
  ren_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rddataEn |=> !rddataEn);

  // R5
  address_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(accepted && busWe && busAdr == ADR_W'(2)) |=> $stable(address));

  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(accepted && busWe && busAdr == ADR_W'(3)) |=> $stable(bank));
endmodule

bind dfi_phase_injector dfi_inj_chk #(
  .ADR_W(ADR_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W)
) uChk (.*);

// File: tb/sim_dfi_phase_injector.sv
`timescale 1ns/1ps
module sim_dfi_phase_injector;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busCyc = 1'b0, busStb = 1'b0, busWe = 1'b0;
  logic [7:0]  busAdr = '0;
  logic [31:0] busDatW = '0;
  logic [3:0]  busSel = '0;
  logic [31:0] busDatR;
  logic        busAck, cke, csN, weN, casN, rasN, actN;
  logic [13:0] address;
  logic [2:0]  bank;
  logic [15:0] wrdata;
  logic [1:0]  wrdataMask;
  logic        wrdataEn, rddataEn;

  int nChecks = 0;
  int nFails = 0;
  int wenCount = 0;
  int renCount = 0;
  logic [5:0] duringCmd, afterCmd;
  logic [31:0] rd;

  always #4 clk = ~clk;

  dfi_phase_injector u0 (.*);

  always @(negedge clk) begin
    if (rstN && wrdataEn) wenCount++;
    if (rstN && rddataEn) renCount++;
  end

  // vector table: index, data, sel, expected readback
  localparam int NV = 12;
  localparam logic [7:0]  VEC_IDX  [NV] = '{8'd2, 8'd2, 8'd2, 8'd3, 8'd3, 8'd5,
                                            8'd5, 8'd4, 8'd4, 8'd0, 8'd1, 8'd6};
  localparam logic [31:0] VEC_DATA [NV] = '{32'h0000_0CDC, 32'hFFFF_FFFF, 32'h0000_1200,
                                            32'h0000_00A8, 32'h0000_0005, 32'h0000_00CC,
                                            32'hABCD_1234, 32'h0000_003F, 32'h0000_FF00,
                                            32'h0000_0002, 32'h0000_FFFF, 32'h0000_1234};
  localparam logic [3:0]  VEC_SEL  [NV] = '{4'hF, 4'hF, 4'h2, 4'hF, 4'hF, 4'hF,
                                            4'h1, 4'hF, 4'hE, 4'hF, 4'hF, 4'hF};
  localparam logic [31:0] VEC_EXP  [NV] = '{32'h0CDC, 32'h3FFF, 32'h12FF, 32'h0000,
                                            32'h0005, 32'h00CC, 32'h0034, 32'h003F,
                                            32'h003F, 32'h0002, 32'h0000, 32'h0000};
  string vecTag [NV] = '{"R10", "R5", "R4", "R5", "R10", "R10",
                         "R4", "R10", "R4", "R7", "R10", "R3"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] idx, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    busCyc = 1'b1; busStb = 1'b1; busWe = 1'b1; busAdr = idx; busDatW = d; busSel = s;
    @(negedge clk);
    duringCmd = {csN, weN, casN, rasN, wrdataEn, rddataEn};
    chk("R2 ack after write", 32'(busAck), 32'd1);
    busCyc = 1'b0; busStb = 1'b0; busWe = 1'b0;
    @(negedge clk);
    afterCmd = {csN, weN, casN, rasN, wrdataEn, rddataEn};
    chk("R2 ack single cycle", 32'(busAck), 32'd0);
  endtask

  task automatic busRead(input logic [7:0] idx, output logic [31:0] d);
    @(negedge clk);
    busCyc = 1'b1; busStb = 1'b1; busWe = 1'b0; busAdr = idx; busSel = 4'hF;
    @(negedge clk);
    d = busDatR;
    busCyc = 1'b0; busStb = 1'b0;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 strobes", {28'd0, csN, weN, casN, rasN}, 32'hF);
    chk("R1 actN", 32'(actN), 32'd1);
    chk("R1 enables/mask/cke/ack", {27'd0, wrdataEn, rddataEn, wrdataMask, cke}, 32'd0);
    chk("R1 busAck", 32'(busAck), 32'd0);
    chk("R1 address/bank/wrdata", {address, bank, wrdata}, 33'd0 == 0 ? 32'd0 : 32'd1);

    for (int i = 0; i < NV; i++) begin
      busWrite(VEC_IDX[i], VEC_DATA[i], VEC_SEL[i]);
      busRead(VEC_IDX[i], rd);
      chk(vecTag[i], rd, VEC_EXP[i]);
    end

    // R5 / R6 outputs follow registers
    busWrite(8'd2, 32'h0000_0CDC, 4'hF);
    chk("R5 address output", 32'(address), 32'h0CDC);
    busWrite(8'd3, 32'h0000_00A8, 4'hF);
    chk("R5 bank truncated", 32'(bank), 32'd0);
    busWrite(8'd3, 32'h0000_0006, 4'hF);
    chk("R5 bank output", 32'(bank), 32'd6);
    busWrite(8'd5, 32'h0000_00CC, 4'hF);
    chk("R6 wrdata output", 32'(wrdata), 32'h00CC);

    // R7 clock enable, R4 lane masking on control
    busWrite(8'd0, 32'h0000_0002, 4'hF);
    chk("R7 cke set", 32'(cke), 32'd1);
    busWrite(8'd0, 32'h0000_0000, 4'h0);
    chk("R4 cke unchanged with no lanes", 32'(cke), 32'd1);
    busWrite(8'd0, 32'h0000_0000, 4'hF);
    chk("R7 cke clear", 32'(cke), 32'd0);

    // R3 unmapped write changes nothing
    busWrite(8'd7, 32'hFFFF_FFFF, 4'hF);
    chk("R3 unmapped address", 32'(address), 32'h0CDC);
    chk("R3 unmapped bank", 32'(bank), 32'd6);
    chk("R3 unmapped cke", 32'(cke), 32'd0);
    busWrite(8'd9, 32'hFFFF_FFFF, 4'hF);
    chk("R3 far index wrdata", 32'(wrdata), 32'h00CC);

    // R9 write enable pulses, two issues give two pulses
    busWrite(8'd4, 32'h0000_0010, 4'hF);
    w0 = wenCount;
    busWrite(8'd1, 32'h0000_0001, 4'hF);
    chk("R9 wen during issue", 32'(duringCmd), 32'b111110);
    chk("R9 wen after issue", 32'(afterCmd), 32'b111100);
    chk("R9 one pulse", 32'(wenCount - w0), 32'd1);
    busWrite(8'd1, 32'h0000_0000, 4'hF);
    chk("R9 second pulse with zero data", 32'(wenCount - w0), 32'd2);
    chk("R9 no read pulse", 32'(renCount), 32'd1);

    // R9 read enable
    busWrite(8'd4, 32'h0000_0020, 4'hF);
    busWrite(8'd1, 32'h0000_0001, 4'hF);
    chk("R9 ren during issue", 32'(duringCmd), 32'b111101);
    chk("R9 ren after issue", 32'(afterCmd), 32'b111100);

    // R8 strobe mapping
    busWrite(8'd4, 32'h0000_000F, 4'hF);
    busWrite(8'd1, 32'h0000_0001, 4'hF);
    chk("R8 all strobes low", 32'(duringCmd), 32'b000000);
    chk("R8 strobes released", 32'(afterCmd), 32'b111100);
    busWrite(8'd4, 32'h0000_0003, 4'hF);
    busWrite(8'd1, 32'h0000_0001, 4'hF);
    chk("R8 cs and we only", 32'(duringCmd), 32'b001100);
    busWrite(8'd4, 32'h0000_000C, 4'hF);
    busWrite(8'd1, 32'h0000_0001, 4'hF);
    chk("R8 cas and ras only", 32'(duringCmd), 32'b110000);

    // R11 constant outputs after activity
    chk("R11 actN high", 32'(actN), 32'd1);
    chk("R11 mask low", 32'(wrdataMask), 32'd0);

    finishRun();
  end
endmodule